// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Status Flags

This block multiplies two signed operands and either adds the product to a wide signed accumulator or subtracts it. In integer mode the product is used at its natural binary weight. In fractional mode the operands are signed fractions. The product is doubled to drop the redundant sign bit. A control bit then either truncates it to a 40-bit fraction or rounds it to 40 bits, with exact halves resolved toward an even result. Every operation is requested by a one-cycle start strobe. A load request takes the accumulator value from a dedicated data input instead.

Four status flags follow each operation: negative, zero, overflow and extension overflow. Overflow is built from a sticky product-overflow history and an accumulation-overflow term. Extension overflow shows that the result has left the 32-bit integer range or the 40-bit fractional range while the wide accumulator still holds it exactly. A host sequences loads and accumulations and reads the accumulator and flags once the done pulse appears.

Top module: `mac_frac_unit`

## Requirements
- R1: In integer mode (frac_i=0) an accumulate adds the sign-extended low 48 bits of the signed 32x32 product to the accumulator (sub_i=0), or subtracts them (sub_i=1). The 48-bit result wraps.
- R2: In fractional mode with round_i=0, the product is doubled to a 64-bit value. Its bits [63:24] form a 40-bit signed contribution, and the 24 dropped bits are discarded. The contribution is sign-extended to 48 bits.
- R3: In fractional mode with round_i=1, the 40-bit contribution is incremented when the dropped 24 bits exceed 0x800000. It is also incremented when they equal 0x800000 and the contribution's bit 0 is 1.
- R4: After every load, add or subtract, flag_n_o equals accumulator bit 47 and flag_z_o is 1 exactly when the accumulator is zero.
- R5: A product overflow occurs in integer mode when the product lies outside the signed 48-bit range, and in fractional mode when both operands are -2^31. It sets a history bit that only a load clears. The overflow flag is set after any add or subtract while the history bit is set.
- R6: An add or subtract whose exact result leaves the signed 48-bit range sets flag_v_o for that operation only, unless the history bit keeps it set.
- R7: After an add or subtract without accumulation overflow, flag_ev_o is 1 when the result lies outside the signed 32-bit range (frac_i=0) or the signed 40-bit range (frac_i=1). Otherwise it is 0, so a later operation that returns into range clears it. Accumulation overflow forces it to 0.
- R8: start_i with load_i=1 writes load_data_i into the accumulator and clears flag_v_o and the history bit. It sets flag_ev_o by the R7 range rule for the current frac_i. Operand and sub inputs are ignored.
- R9: Results appear in the cycle after the clock edge that samples start_i. done_o is high for exactly that cycle. Without start_i the accumulator and flags hold.
- R10: Reset clears the accumulator, all flags, the history bit and done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle operation request |
| load_i | input | 1 | With start_i: load instead of accumulate |
| sub_i | input | 1 | 1 subtracts the product, 0 adds it |
| frac_i | input | 1 | 1 fractional mode, 0 integer mode |
| round_i | input | 1 | Fractional mode: 1 round, 0 truncate |
| op_a_i | input | 32 | First signed operand |
| op_b_i | input | 32 | Second signed operand |
| load_data_i | input | 48 | Value written by a load |
| acc_o | output | 48 | Accumulator |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_ev_o | output | 1 | Extension-overflow flag |
| done_o | output | 1 | Result-valid pulse |

## Verification
The bench builds the unit with its default widths: 32-bit operands, a 48-bit accumulator, a 32-bit integer range and a 40-bit fractional range. At these widths a single -2^31 by -2^31 product overflows in both modes. Loading the largest 48-bit value followed by one unit product reaches accumulation overflow. Operands of 2^22 multiples place exact halves in the dropped 24 bits. This makes the round-to-even ties, the sticky history and the extension-range crossings reachable with short directed sequences, and a random mix exercises the rest.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADD  = 2'd2,
    OP_SUB  = 2'd3
  } mac_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic ext_ovf;
  } mac_flags_t;

endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int OP_W   = 32,
  parameter int ACC_W  = 48,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  logic              frac_i,
  output logic [PROD_W-1:0] prod_o,
  output logic              ovf_o
);

  logic signed [PROD_W-1:0] a_x;
  logic signed [PROD_W-1:0] b_x;
  logic signed [PROD_W-1:0] raw;
  logic [PROD_W-ACC_W:0]    upper;
  logic                     int_ovf;
  logic                     frac_ovf;

  assign a_x = {{OP_W{a_i[OP_W-1]}}, a_i};
  assign b_x = {{OP_W{b_i[OP_W-1]}}, b_i};
  assign raw = a_x * b_x;

  // integer product must fit a signed accumulator-wide value
  assign upper   = raw[PROD_W-1:ACC_W-1];
  assign int_ovf = !((&upper) || !(|upper));

  // doubling loses information only when the two top bits differ
  assign frac_ovf = raw[PROD_W-1] ^ raw[PROD_W-2];

  assign prod_o = frac_i ? {raw[PROD_W-2:0], 1'b0} : raw;
  assign ovf_o  = frac_i ? frac_ovf : int_ovf;

endmodule

// File: rtl/mac_align.sv
module mac_align #(
  parameter int PROD_W = 64,
  parameter int ACC_W  = 48,
  parameter int FRAC_W = 40,
  localparam int DROP_W = PROD_W - FRAC_W
) (
  input  logic [PROD_W-1:0] prod_i,
  input  logic              frac_i,
  input  logic              round_i,
  output logic [ACC_W-1:0]  contrib_o
);

  localparam logic [DROP_W-1:0] HALF = DROP_W'(1) << (DROP_W - 1);

  logic [FRAC_W-1:0] hi;
  logic [DROP_W-1:0] lo;
  logic              bump;
  logic [FRAC_W-1:0] frac_val;

  assign hi = prod_i[PROD_W-1:DROP_W];
  assign lo = prod_i[DROP_W-1:0];

  // round half to even: exact halves only move an odd value
  assign bump     = round_i && ((lo > HALF) || ((lo == HALF) && hi[0]));
  assign frac_val = hi + FRAC_W'(bump);

  assign contrib_o = frac_i ? {{(ACC_W-FRAC_W){frac_val[FRAC_W-1]}}, frac_val}
                            : prod_i[ACC_W-1:0];

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int ACC_W = 48
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] contrib_i,
  input  logic             sub_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             ovf_o
);

  logic [ACC_W:0] ext_a;
  logic [ACC_W:0] ext_c;
  logic [ACC_W:0] sum_x;

  assign ext_a = {acc_i[ACC_W-1], acc_i};
  assign ext_c = {contrib_i[ACC_W-1], contrib_i};
  assign sum_x = sub_i ? (ext_a - ext_c) : (ext_a + ext_c);

  assign sum_o = sum_x[ACC_W-1:0];
  assign ovf_o = sum_x[ACC_W] ^ sum_x[ACC_W-1];

endmodule

// File: rtl/mac_frac_unit.sv
module mac_frac_unit #(
  parameter int OP_W   = 32,
  parameter int ACC_W  = 48,
  parameter int INT_W  = 32,
  parameter int FRAC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             load_i,
  input  logic             sub_i,
  input  logic             frac_i,
  input  logic             round_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic [ACC_W-1:0] load_data_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_v_o,
  output logic             flag_ev_o,
  output logic             done_o
);
  import mac_pkg::*;

  localparam int PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] prod_w;
  logic              prod_ovf_w;
  logic [ACC_W-1:0]  contrib_w;
  logic [ACC_W-1:0]  sum_w;
  logic              acc_ovf_w;
  mac_op_e           op_w;

  logic [ACC_W-1:0]  acc_q, acc_d;
  mac_flags_t        flags_q, flags_d;
  logic              hist_q, hist_d;
  logic              done_q;
  int                lim_w;

  function automatic logic in_range(logic [ACC_W-1:0] v, int w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ACC_W; i++) begin
      if ((i >= w - 1) && (v[i] != v[ACC_W-1])) ok = 1'b0;
    end
    return ok;
  endfunction

  mac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_product (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .frac_i (frac_i),
    .prod_o (prod_w),
    .ovf_o  (prod_ovf_w)
  );

  mac_align #(.PROD_W(PROD_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_align (
    .prod_i    (prod_w),
    .frac_i    (frac_i),
    .round_i   (round_i),
    .contrib_o (contrib_w)
  );

  mac_accum #(.ACC_W(ACC_W)) u_accum (
    .acc_i     (acc_q),
    .contrib_i (contrib_w),
    .sub_i     (sub_i),
    .sum_o     (sum_w),
    .ovf_o     (acc_ovf_w)
  );

  assign lim_w = frac_i ? FRAC_W : INT_W;

  always_comb begin
    if (!start_i)     op_w = OP_IDLE;
    else if (load_i)  op_w = OP_LOAD;
    else if (sub_i)   op_w = OP_SUB;
    else              op_w = OP_ADD;
  end

  always_comb begin
    acc_d   = acc_q;
    flags_d = flags_q;
    hist_d  = hist_q;
    unique case (op_w)
      OP_LOAD: begin
        acc_d           = load_data_i;
        hist_d          = 1'b0;
        flags_d.ovf     = 1'b0;
        flags_d.ext_ovf = !in_range(load_data_i, lim_w);
      end
      OP_ADD, OP_SUB: begin
        acc_d           = sum_w;
        hist_d          = hist_q | prod_ovf_w;
        flags_d.ovf     = hist_d | acc_ovf_w;
        flags_d.ext_ovf = !acc_ovf_w && !in_range(sum_w, lim_w);
      end
      default: ;
    endcase
    if (op_w != OP_IDLE) begin
      flags_d.neg  = acc_d[ACC_W-1];
      flags_d.zero = (acc_d == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flags_q <= '0;
      hist_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      flags_q <= flags_d;
      hist_q  <= hist_d;
      done_q  <= start_i;
    end
  end

  assign acc_o     = acc_q;
  assign flag_n_o  = flags_q.neg;
  assign flag_z_o  = flags_q.zero;
  assign flag_v_o  = flags_q.ovf;
  assign flag_ev_o = flags_q.ext_ovf;
  assign done_o    = done_q;

endmodule

// File: rtl/mac_frac_checker.sv
module mac_frac_checker #(
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             load_i,
  input logic [ACC_W-1:0] load_data_i,
  input logic [ACC_W-1:0] acc_o,
  input logic             flag_n_o,
  input logic             flag_z_o,
  input logic             flag_v_o,
  input logic             flag_ev_o,
  input logic             done_o,
  input logic             prod_ovf_w,
  input logic             acc_ovf_w
);

  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!done_o && $stable(acc_o) && $stable(flag_v_o) && $stable(flag_ev_o))); // R9

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && load_i) |=> (acc_o == $past(load_data_i))); // R8

  AST_LOAD_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && load_i) |=> !flag_v_o); // R8

  AST_PROD_OVF_SETS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !load_i && prod_ovf_w) |=> flag_v_o); // R5

  AST_ACC_OVF_SETS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !load_i && acc_ovf_w) |=> (flag_v_o && !flag_ev_o)); // R6

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_z_o == (acc_o == '0))); // R4

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_n_o == acc_o[ACC_W-1])); // R4

endmodule

bind mac_frac_unit mac_frac_checker #(.ACC_W(ACC_W)) u_mac_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .load_i      (load_i),
  .load_data_i (load_data_i),
  .acc_o       (acc_o),
  .flag_n_o    (flag_n_o),
  .flag_z_o    (flag_z_o),
  .flag_v_o    (flag_v_o),
  .flag_ev_o   (flag_ev_o),
  .done_o      (done_o),
  .prod_ovf_w  (prod_ovf_w),
  .acc_ovf_w   (acc_ovf_w)
);

// File: tb/test_mac_frac_unit.sv
module test_mac_frac_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, load_i = 1'b0, sub_i = 1'b0, frac_i = 1'b0, round_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [47:0] load_data_i = '0;
  logic [47:0] acc_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_ev_o, done_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  // reference state
  logic [47:0] m_acc = '0;
  bit m_n, m_z, m_v, m_ev, m_hist, m_done;

  always #10 clk = ~clk;

  mac_frac_unit i_mac_frac_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i), .sub_i(sub_i),
    .frac_i(frac_i), .round_i(round_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .load_data_i(load_data_i), .acc_o(acc_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .flag_v_o(flag_v_o), .flag_ev_o(flag_ev_o), .done_o(done_o)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit fits(logic signed [127:0] v, int w);
    logic signed [127:0] hi, lo;
    hi = (128'sd1 <<< (w - 1)) - 1;
    lo = -(128'sd1 <<< (w - 1));
    return (v <= hi) && (v >= lo);
  endfunction

  // behavioural model, updated on each edge
  always @(posedge clk) begin
    logic signed [127:0] pa, pb, p, f, q, c, as, r;
    logic signed [63:0]  f64;
    logic signed [47:0]  c48, a48;
    logic [23:0]         rem;
    bit                  povf, aovf;
    int                  lim;
    if (!rst_n) begin
      m_acc = '0; m_n = 0; m_z = 0; m_v = 0; m_ev = 0; m_hist = 0; m_done = 0;
    end else begin
      m_done = start_i;
      lim = frac_i ? 40 : 32;
      if (start_i && load_i) begin
        m_acc = load_data_i;
        a48 = load_data_i;
        m_hist = 0; m_v = 0;
        m_ev = !fits(128'(a48), lim);
        m_n = m_acc[47]; m_z = (m_acc == 0);
      end else if (start_i) begin
        pa = 128'($signed(op_a_i));
        pb = 128'($signed(op_b_i));
        p = pa * pb;
        if (!frac_i) begin
          povf = !fits(p, 48);
          c48 = p[47:0];
          c = 128'(c48);
        end else begin
          f = p * 2;
          povf = (f >= (128'sd1 <<< 63));
          f64 = f[63:0];
          q = 128'(f64) >>> 24;
          rem = f64[23:0];
          if (round_i && ((rem > 24'h800000) || (rem == 24'h800000 && q[0]))) q = q + 1;
          c = q;
        end
        a48 = m_acc;
        as = 128'(a48);
        r = sub_i ? as - c : as + c;
        aovf = !fits(r, 48);
        m_acc = r[47:0];
        a48 = m_acc;
        m_hist = m_hist | povf;
        m_v = m_hist | aovf;
        m_ev = !aovf && !fits(128'(a48), lim);
        m_n = m_acc[47]; m_z = (m_acc == 0);
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(acc_o === m_acc, "R1 R2 R3 R8 acc", 64'(acc_o), 64'(m_acc));
      chk(flag_n_o === m_n, "R4 neg", 64'(flag_n_o), 64'(m_n));
      chk(flag_z_o === m_z, "R4 zero", 64'(flag_z_o), 64'(m_z));
      chk(flag_v_o === m_v, "R5 R6 ovf", 64'(flag_v_o), 64'(m_v));
      chk(flag_ev_o === m_ev, "R7 ext_ovf", 64'(flag_ev_o), 64'(m_ev));
      chk(done_o === m_done, "R9 done", 64'(done_o), 64'(m_done));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_op(bit ld, bit sb, bit fr, bit rn, logic [31:0] a, logic [31:0] b,
                       logic [47:0] d);
    @(negedge clk);
    start_i = 1; load_i = ld; sub_i = sb; frac_i = fr; round_i = rn;
    op_a_i = a; op_b_i = b; load_data_i = d;
    @(negedge clk);
    start_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(acc_o == 0 && {flag_n_o, flag_z_o, flag_v_o, flag_ev_o, done_o} == 0,
        "R10 reset", 64'(acc_o), 64'h0);

    // integer add and subtract
    do_op(1, 0, 0, 0, 0, 0, 48'h0);
    do_op(0, 0, 0, 0, 32'd7, -32'sd3, 0);
    chk(acc_o == 48'hFFFF_FFFF_FFEB && flag_n_o, "R1 int add", 64'(acc_o), 64'hFFFF_FFFF_FFEB);
    chk(done_o == 1, "R9 done pulse", 64'(done_o), 64'h1);
    do_op(0, 1, 0, 0, 32'd7, -32'sd3, 0);
    chk(acc_o == 0 && flag_z_o, "R1 R4 int sub to zero", 64'(acc_o), 64'h0);

    // fractional truncate and rounding
    do_op(1, 0, 1, 0, 0, 0, 48'h0);
    do_op(0, 0, 1, 0, 32'(3 << 22), 32'd1, 0);
    chk(acc_o == 48'd1, "R2 truncate", 64'(acc_o), 64'd1);
    do_op(0, 0, 1, 1, 32'(3 << 22), 32'd1, 0);
    chk(acc_o == 48'd3, "R3 tie odd rounds up", 64'(acc_o), 64'd3);
    do_op(0, 0, 1, 1, 32'(1 << 22), 32'd1, 0);
    chk(acc_o == 48'd3, "R3 tie even stays", 64'(acc_o), 64'd3);
    do_op(0, 0, 1, 1, -32'(3 << 22), 32'd1, 0);
    chk(acc_o == 48'd1, "R3 negative tie", 64'(acc_o), 64'd1);
    do_op(0, 0, 1, 1, 32'((1 << 22) + 1), 32'd1, 0);
    chk(acc_o == 48'd2, "R3 above half", 64'(acc_o), 64'd2);

    // extension range
    do_op(1, 0, 0, 0, 0, 0, 48'h0);
    do_op(0, 0, 0, 0, 32'(1 << 16), 32'(1 << 15), 0);
    chk(flag_ev_o == 1, "R7 int range left", 64'(flag_ev_o), 64'h1);
    do_op(0, 1, 0, 0, 32'(1 << 16), 32'(1 << 15), 0);
    chk(flag_ev_o == 0, "R7 back in range", 64'(flag_ev_o), 64'h0);
    do_op(1, 0, 1, 0, 0, 0, 48'h0000_8000_0000);
    chk(flag_ev_o == 0, "R7 R8 frac range load", 64'(flag_ev_o), 64'h0);
    do_op(1, 0, 0, 0, 0, 0, 48'h0000_8000_0000);
    chk(flag_ev_o == 1, "R7 R8 int range load", 64'(flag_ev_o), 64'h1);

    // product overflow history
    do_op(1, 0, 0, 0, 0, 0, 48'h0);
    do_op(0, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 0);
    chk(flag_v_o == 1, "R5 int product overflow", 64'(flag_v_o), 64'h1);
    do_op(0, 0, 0, 0, 32'd2, 32'd2, 0);
    chk(flag_v_o == 1, "R5 history sticky", 64'(flag_v_o), 64'h1);
    do_op(1, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 48'd5);
    chk(flag_v_o == 0 && acc_o == 48'd5, "R8 load clears", 64'(acc_o), 64'd5);
    do_op(0, 0, 1, 1, 32'h8000_0000, 32'h8000_0000, 0);
    chk(flag_v_o == 1, "R5 frac product overflow", 64'(flag_v_o), 64'h1);

    // accumulation overflow
    do_op(1, 0, 0, 0, 0, 0, 48'h7FFF_FFFF_FFFF);
    do_op(0, 0, 0, 0, 32'd1, 32'd1, 0);
    chk(acc_o == 48'h8000_0000_0000 && flag_v_o && !flag_ev_o, "R6 R7 acc overflow",
        64'(acc_o), 64'h8000_0000_0000);
    do_op(1, 0, 0, 0, 0, 0, 48'h0);
    do_op(0, 0, 0, 0, 32'd1, 32'd1, 0);
    chk(flag_v_o == 0, "R6 not sticky", 64'(flag_v_o), 64'h0);

    // idle hold
    repeat (3) @(negedge clk);
    chk(acc_o == 48'd1 && done_o == 0, "R9 idle hold", 64'(acc_o), 64'd1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      int sa, sb2;
      sa = $urandom % 4; sb2 = $urandom % 4;
      a = (sa == 0) ? 32'($urandom % 512) - 32'd256 : (sa == 1) ? $urandom :
          (sa == 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      b = (sb2 == 0) ? 32'($urandom % 512) - 32'd256 : (sb2 == 1) ? $urandom :
          (sb2 == 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      if (($urandom % 4) == 0) begin
        @(negedge clk);
      end else begin
        do_op(($urandom % 10) == 0, 1'($urandom), 1'($urandom), 1'($urandom), a, b,
              {16'($urandom), $urandom});
      end
    end

    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule